// File: doc/BRIEF.md
# Buffered Serial Transmitter with Automatic Request-to-Send

This block turns characters written by a processor into an asynchronous serial stream. Characters are queued in a small word FIFO. The usable depth of that FIFO is programmable from one to four entries. A transmit engine removes one character at a time and sends it on `txd`. Each frame is a low start bit, then 5 to 9 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. Every bit lasts from one `baud_tick` pulse to the next. The baud generator and register decode live outside the block. They supply the tick and a set of configuration inputs.

The block can own the `rts` line so that software need not time it. In automatic mode it raises `rts` one whole bit period before the first start bit of a burst. It keeps `rts` high while queued characters follow back to back. It drops `rts` at the end of the last stop bit, in the same cycle that `tx_empty` rises. In manual mode `rts` simply mirrors a control input. Independently of the `rts` mode, transmission can be held off until the far end asserts `cts`. A level output and a below-threshold flag give an interrupt source, and a sticky flag records writes that were refused.

Top module: `uart_tx_autorts`

## Requirements
- R1: `txd` idles high. A frame is a low start bit followed by N data bits, least significant bit first, with N = `cfg_len_sel` + 5 for selections 0 to 4 and N = 9 for selections 5 to 7. Each bit lasts exactly one `baud_tick` period, and data bits above N are not sent.
- R2: With N = 9 the ninth data bit sent is `wr_data[8]`, the address/data marker. Characters leave in the order they were accepted, and each accepted write produces exactly one frame.
- R3: `cfg_parity` selects the parity bit that follows the data: 0 none, 1 odd (data plus parity hold an odd count of ones), 2 even, 3 always 1, 4 always 0. Codes 5 to 7 mean none.
- R4: After the data bits and any parity bit come one high stop bit, or two when `cfg_two_stop` is 1.
- R5: With `cfg_auto_rts` = 1, `rts` goes high at least one full `baud_tick` period before the start bit of the first character of a burst. It stays high throughout every frame of the burst.
- R6: With `cfg_auto_rts` = 1, when the last stop bit ends with the FIFO empty, `rts` falls in the same cycle that `tx_empty` rises.
- R7: With `cfg_auto_rts` = 0, `rts` equals `cfg_rts_manual`, and a queued character starts at the next `baud_tick`.
- R8: With `cfg_cts_gate` = 1 and `cts` low, no new character is started: `txd` stays high and `fifo_level` does not fall.
- R9: The effective FIFO depth is `cfg_depth_m1` + 1. A write while `fifo_level` is at least that depth is dropped. Such a write sets `overflow`, which stays set until reset.
- R10: `fifo_level` counts the characters waiting in the FIFO, and `below_thr` is 1 exactly when `fifo_level` < `cfg_thresh`.
- R11: After reset `txd` = 1, `tx_empty` = 1, `fifo_level` = 0, `overflow` = 0 and the automatic `rts` state is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle strobe that marks each bit boundary |
| cfg_len_sel | input | 3 | Character length select (0..4 give 5..9 bits) |
| cfg_parity | input | 3 | Parity mode |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_auto_rts | input | 1 | 1 lets the transmitter drive `rts` |
| cfg_cts_gate | input | 1 | 1 holds new characters until `cts` is high |
| cfg_rts_manual | input | 1 | Value of `rts` in manual mode |
| cfg_depth_m1 | input | 2 | Effective FIFO depth minus one |
| cfg_thresh | input | 3 | Threshold for `below_thr` |
| wr_en | input | 1 | Write strobe for one character |
| wr_data | input | 9 | Character; bit 8 is the address/data marker |
| cts | input | 1 | Clear-to-send from the far end, active high |
| txd | output | 1 | Serial data out |
| rts | output | 1 | Request-to-send, active high |
| tx_empty | output | 1 | FIFO empty and engine idle |
| below_thr | output | 1 | FIFO level below threshold (interrupt request) |
| overflow | output | 1 | Sticky flag for a dropped write |
| fifo_level | output | 3 | Number of queued characters |

## Verification
The properties assume that the configuration inputs change only while `tx_empty` is high and that `baud_tick` pulses last one cycle. If the configuration could move during a frame, the `rts` and gating relations would have no fixed meaning. The stimulus changes settings only after it has waited for `tx_empty` and for its own decoder to drain. It spaces ticks a fixed number of cycles apart. In the random phase it writes only when the level port shows room. Overflow is provoked only in directed runs where `cts` gating holds the engine still, so the number of accepted writes can be known in advance.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int CHAR_MAX = 9;
    localparam int BCW      = 4;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEAD  = 3'd1,
        ST_START = 3'd2,
        ST_DATA  = 3'd3,
        ST_PAR   = 3'd4,
        ST_STOP1 = 3'd5,
        ST_STOP2 = 3'd6
    } tx_state_e;

    typedef struct packed {
        logic [2:0] len_sel;
        logic [2:0] parity;
        logic       two_stop;
        logic       auto_rts;
        logic       cts_gate;
    } tx_cfg_t;

    // number of data bits sent for a length selection
    function automatic logic [BCW-1:0] char_bits(input logic [2:0] sel);
        return (sel > 3'd4) ? BCW'(CHAR_MAX) : BCW'(sel) + BCW'(5);
    endfunction

    function automatic logic parity_on(input logic [2:0] mode);
        return (mode >= 3'd1) && (mode <= 3'd4);
    endfunction

    // parity bit over the low n bits of d
    function automatic logic parity_bit(input logic [2:0] mode,
                                        input logic [CHAR_MAX-1:0] d,
                                        input logic [BCW-1:0] n);
        logic x;
        x = 1'b0;
        for (int i = 0; i < CHAR_MAX; i++) begin
            if (BCW'(i) < n) x = x ^ d[i];
        end
        case (mode)
            3'd1:    return ~x;
            3'd2:    return x;
            3'd3:    return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 9,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] depth_m1,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  pop_data,
    output logic [CW-1:0] level,
    output logic          empty,
    output logic          overflow
);

    typedef struct packed {
        logic [PW-1:0] rd;
        logic [PW-1:0] wr;
        logic [CW-1:0] cnt;
        logic          ovf;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [CW-1:0] lim;
    logic          accept;
    logic          take;
    logic [W-1:0]  ent_w [DEPTH];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    // programmed depth, never above the physical one
    assign lim    = (int'(depth_m1) >= DEPTH) ? CW'(DEPTH) : CW'(depth_m1) + CW'(1);
    assign accept = push && (st_q.cnt < lim);
    assign take   = pop && (st_q.cnt != '0);

    always_comb begin
        st_d = st_q;
        if (accept) st_d.wr = bump(st_q.wr);
        if (take)   st_d.rd = bump(st_q.rd);
        if (accept && !take)      st_d.cnt = st_q.cnt + CW'(1);
        else if (take && !accept) st_d.cnt = st_q.cnt - CW'(1);
        if (push && !accept) st_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic [W-1:0] ent_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             ent_q <= '0;
            else if (accept && st_q.wr == PW'(g))   ent_q <= push_data;
        end
        assign ent_w[g] = ent_q;
    end

    assign pop_data = ent_w[st_q.rd];
    assign level    = st_q.cnt;
    assign empty    = (st_q.cnt == '0);
    assign overflow = st_q.ovf;

endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
    import uart_tx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                baud_tick,
    input  tx_cfg_t             cfg,
    input  logic                cts,
    input  logic                q_empty,
    input  logic [CHAR_MAX-1:0] q_data,
    output logic                q_pop,
    output logic                txd,
    output logic                rts_auto,
    output logic                idle
);

    typedef struct packed {
        tx_state_e           state;
        logic [CHAR_MAX-1:0] shreg;
        logic [BCW-1:0]      bitcnt;
        logic                par;
        logic                rts;
    } eng_st_t;

    eng_st_t st_d, st_q;
    logic [BCW-1:0] n_bits;
    logic [BCW-1:0] last_idx;
    logic           start_ok;
    logic           do_load;
    logic           frame_done;

    assign n_bits   = char_bits(cfg.len_sel);
    assign last_idx = n_bits - BCW'(1);
    assign start_ok = !q_empty && (!cfg.cts_gate || cts);

    always_comb begin
        st_d       = st_q;
        q_pop      = 1'b0;
        do_load    = 1'b0;
        frame_done = 1'b0;
        if (!cfg.auto_rts) st_d.rts = 1'b0;
        if (baud_tick) begin
            case (st_q.state)
                ST_IDLE: begin
                    if (start_ok) begin
                        if (cfg.auto_rts && !st_q.rts) begin
                            // lead-in bit: request line first, start bit one tick later
                            st_d.rts   = 1'b1;
                            st_d.state = ST_LEAD;
                        end else begin
                            do_load = 1'b1;
                        end
                    end
                end
                ST_LEAD: begin
                    if (!q_empty) begin
                        do_load = 1'b1;
                    end else begin
                        st_d.state = ST_IDLE;
                        st_d.rts   = 1'b0;
                    end
                end
                ST_START: st_d.state = ST_DATA;
                ST_DATA: begin
                    if (st_q.bitcnt == last_idx) begin
                        st_d.state = parity_on(cfg.parity) ? ST_PAR : ST_STOP1;
                    end else begin
                        st_d.shreg  = st_q.shreg >> 1;
                        st_d.bitcnt = st_q.bitcnt + BCW'(1);
                    end
                end
                ST_PAR:   st_d.state = ST_STOP1;
                ST_STOP1: begin
                    if (cfg.two_stop) st_d.state = ST_STOP2;
                    else              frame_done = 1'b1;
                end
                ST_STOP2: frame_done = 1'b1;
                default:  st_d.state = ST_IDLE;
            endcase
        end
        if (frame_done) begin
            if (start_ok) begin
                do_load = 1'b1;
            end else begin
                st_d.state = ST_IDLE;
                if (q_empty) st_d.rts = 1'b0;
            end
        end
        if (do_load) begin
            st_d.state  = ST_START;
            st_d.shreg  = q_data;
            st_d.bitcnt = '0;
            st_d.par    = parity_bit(cfg.parity, q_data, n_bits);
            q_pop       = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{state: ST_IDLE, default: '0};
        else        st_q <= st_d;
    end

    always_comb begin
        case (st_q.state)
            ST_START: txd = 1'b0;
            ST_DATA:  txd = st_q.shreg[0];
            ST_PAR:   txd = st_q.par;
            default:  txd = 1'b1;
        endcase
    end

    assign rts_auto = st_q.rts;
    assign idle     = (st_q.state == ST_IDLE);

endmodule

// File: rtl/uart_tx_autorts.sv
module uart_tx_autorts
    import uart_tx_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                baud_tick,
    input  logic [2:0]          cfg_len_sel,
    input  logic [2:0]          cfg_parity,
    input  logic                cfg_two_stop,
    input  logic                cfg_auto_rts,
    input  logic                cfg_cts_gate,
    input  logic                cfg_rts_manual,
    input  logic [PW-1:0]       cfg_depth_m1,
    input  logic [CW-1:0]       cfg_thresh,
    input  logic                wr_en,
    input  logic [CHAR_MAX-1:0] wr_data,
    input  logic                cts,
    output logic                txd,
    output logic                rts,
    output logic                tx_empty,
    output logic                below_thr,
    output logic                overflow,
    output logic [CW-1:0]       fifo_level
);

    tx_cfg_t             cfg;
    logic                q_empty;
    logic                q_pop;
    logic [CHAR_MAX-1:0] q_data;
    logic                rts_auto;
    logic                eng_idle;

    assign cfg = '{len_sel:  cfg_len_sel,
                   parity:   cfg_parity,
                   two_stop: cfg_two_stop,
                   auto_rts: cfg_auto_rts,
                   cts_gate: cfg_cts_gate};

    uart_tx_fifo #(
        .DEPTH (DEPTH),
        .W     (CHAR_MAX)
    ) fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .depth_m1  (cfg_depth_m1),
        .push      (wr_en),
        .push_data (wr_data),
        .pop       (q_pop),
        .pop_data  (q_data),
        .level     (fifo_level),
        .empty     (q_empty),
        .overflow  (overflow)
    );

    uart_tx_engine eng_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .cfg       (cfg),
        .cts       (cts),
        .q_empty   (q_empty),
        .q_data    (q_data),
        .q_pop     (q_pop),
        .txd       (txd),
        .rts_auto  (rts_auto),
        .idle      (eng_idle)
    );

    assign rts       = cfg_auto_rts ? rts_auto : cfg_rts_manual;
    assign tx_empty  = q_empty && eng_idle;
    assign below_thr = (fifo_level < cfg_thresh);

endmodule

// File: rtl/uart_tx_autorts_chk.sv
module uart_tx_autorts_chk #(
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          txd,
    input logic          rts,
    input logic          tx_empty,
    input logic          cts,
    input logic          cfg_cts_gate,
    input logic          cfg_auto_rts,
    input logic          eng_idle,
    input logic          wr_en,
    input logic [PW-1:0] cfg_depth_m1,
    input logic [CW-1:0] level,
    input logic          overflow
);

    logic [CW-1:0] lim_c;
    assign lim_c = CW'(cfg_depth_m1) + CW'(1);

    // R1
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> txd);

    // R5
    rts_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_auto_rts && $fell(txd)) |-> $past(rts));

    // R6
    rts_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_auto_rts && $rose(tx_empty)) |-> !rts);

    // R8
    cts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_idle && cfg_cts_gate && !cts) |=> txd);

    // R9
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && level >= lim_c) |=> overflow);

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R10
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));

    // R10
    level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level == $past(level)) || (level == $past(level) + CW'(1)) ||
        (level == $past(level) - CW'(1)));

endmodule

bind uart_tx_autorts uart_tx_autorts_chk #(.DEPTH(DEPTH)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .txd          (txd),
    .rts          (rts),
    .tx_empty     (tx_empty),
    .cts          (cts),
    .cfg_cts_gate (cfg_cts_gate),
    .cfg_auto_rts (cfg_auto_rts),
    .eng_idle     (eng_idle),
    .wr_en        (wr_en),
    .cfg_depth_m1 (cfg_depth_m1),
    .level        (fifo_level),
    .overflow     (overflow)
);

// File: tb/uart_tx_autorts_tb_top.sv
module uart_tx_autorts_tb_top;

    localparam int BT = 8;          // clocks per bit
    localparam int WD = 190000;     // watchdog limit in cycles

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic [2:0] cfg_len_sel = 3'd3;
    logic [2:0] cfg_parity = 3'd0;
    logic       cfg_two_stop = 1'b0;
    logic       cfg_auto_rts = 1'b0;
    logic       cfg_cts_gate = 1'b0;
    logic       cfg_rts_manual = 1'b0;
    logic [1:0] cfg_depth_m1 = 2'd3;
    logic [2:0] cfg_thresh = 3'd2;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       cts = 1'b1;
    logic       txd, rts, tx_empty, below_thr, overflow;
    logic [2:0] fifo_level;

    int         n_chk = 0;
    int         n_fail = 0;
    int         rts_hi_cnt = 0;
    bit         finished = 0;
    logic [8:0] exp_q [$];

    uart_tx_autorts dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .baud_tick      (baud_tick),
        .cfg_len_sel    (cfg_len_sel),
        .cfg_parity     (cfg_parity),
        .cfg_two_stop   (cfg_two_stop),
        .cfg_auto_rts   (cfg_auto_rts),
        .cfg_cts_gate   (cfg_cts_gate),
        .cfg_rts_manual (cfg_rts_manual),
        .cfg_depth_m1   (cfg_depth_m1),
        .cfg_thresh     (cfg_thresh),
        .wr_en          (wr_en),
        .wr_data        (wr_data),
        .cts            (cts),
        .txd            (txd),
        .rts            (rts),
        .tx_empty       (tx_empty),
        .below_thr      (below_thr),
        .overflow       (overflow),
        .fifo_level     (fifo_level)
    );

    // 50 MHz: 20 time units per period
    initial forever #10 clk = ~clk;

    initial begin
        int tcnt;
        tcnt = 0;
        forever begin
            @(negedge clk);
            tcnt = (tcnt == BT - 1) ? 0 : tcnt + 1;
            baud_tick = (tcnt == 0);
        end
    end

    initial forever begin
        @(negedge clk);
        rts_hi_cnt = rts ? rts_hi_cnt + 1 : 0;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int nbits(input logic [2:0] sel);
        return (sel > 3'd4) ? 9 : int'(sel) + 5;
    endfunction

    function automatic logic [8:0] lenmask(input int n);
        return 9'((10'h1 << n) - 10'h1);
    endfunction

    function automatic logic exp_par(input logic [2:0] mode, input logic [8:0] d, input int n);
        logic x;
        x = ^(d & lenmask(n));
        case (mode)
            3'd1:    return ~x;
            3'd2:    return x;
            3'd3:    return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // independent frame decoder, samples in the middle of every bit
    task automatic decode_frame();
        int         n;
        logic [8:0] d;
        logic [8:0] e;
        bit         par_en;
        n = nbits(cfg_len_sel);
        d = '0;
        par_en = (cfg_parity >= 3'd1) && (cfg_parity <= 3'd4);
        if (cfg_auto_rts)
            chk(rts_hi_cnt >= BT, "R5", "rts lead cycles before start", rts_hi_cnt, BT);
        repeat (BT / 2 - 1) @(negedge clk);
        chk(txd == 1'b0, "R1", "start bit", int'(txd), 0);
        for (int i = 0; i < n; i++) begin
            repeat (BT) @(negedge clk);
            d[i] = txd;
        end
        if (par_en) begin
            repeat (BT) @(negedge clk);
            chk(txd == exp_par(cfg_parity, d, n), "R3", "parity bit",
                int'(txd), int'(exp_par(cfg_parity, d, n)));
        end
        repeat (BT) @(negedge clk);
        chk(txd == 1'b1, "R4", "first stop bit", int'(txd), 1);
        if (cfg_two_stop) begin
            repeat (BT) @(negedge clk);
            chk(txd == 1'b1, "R4", "second stop bit", int'(txd), 1);
        end
        if (cfg_auto_rts)
            chk(rts == 1'b1, "R5", "rts held through frame", int'(rts), 1);
        if (exp_q.size() == 0) begin
            chk(1'b0, "R2", "unexpected frame", int'(d), -1);
        end else begin
            e = exp_q.pop_front();
            chk(d == (e & lenmask(n)), (n == 9) ? "R2" : "R1", "frame data",
                int'(d), int'(e & lenmask(n)));
        end
    endtask

    initial forever begin
        @(negedge clk);
        if (rst_n && txd == 1'b0) decode_frame();
    end

    task automatic do_reset();
        rst_n = 1'b0;
        wr_en = 1'b0;
        exp_q.delete();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic push_char(input logic [8:0] d, input bit accepted);
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
        if (accepted) exp_q.push_back(d);
    endtask

    task automatic drain();
        int guard;
        guard = 0;
        @(negedge clk);
        while ((!tx_empty || exp_q.size() != 0) && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        chk(exp_q.size() == 0, "R2", "characters not delivered", exp_q.size(), 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=%0d expected=%0d", WD, 0);
        finish_run();
    end

    initial begin
        int lows;
        void'($urandom(32'd20240611));

        // R11 reset state
        do_reset();
        chk(txd == 1'b1, "R11", "txd after reset", int'(txd), 1);
        chk(tx_empty == 1'b1, "R11", "tx_empty after reset", int'(tx_empty), 1);
        chk(fifo_level == 3'd0, "R11", "level after reset", int'(fifo_level), 0);
        chk(overflow == 1'b0, "R11", "overflow after reset", int'(overflow), 0);
        chk(below_thr == 1'b1, "R10", "below_thr at level 0", int'(below_thr), 1);
        cfg_auto_rts = 1'b1;
        @(negedge clk);
        chk(rts == 1'b0, "R11", "auto rts after reset", int'(rts), 0);

        // R7 manual rts follows the control input
        cfg_auto_rts = 1'b0;
        cfg_rts_manual = 1'b1;
        @(negedge clk);
        chk(rts == 1'b1, "R7", "manual rts high", int'(rts), 1);
        cfg_rts_manual = 1'b0;
        @(negedge clk);
        chk(rts == 1'b0, "R7", "manual rts low", int'(rts), 0);

        // R2 nine-bit characters with the marker set and clear
        cfg_len_sel = 3'd4;
        cfg_parity = 3'd2;
        push_char(9'h1A5, 1);
        push_char(9'h05A, 1);
        drain();

        // R8 / R10 gating on cts and threshold flag
        do_reset();
        cfg_depth_m1 = 2'd3;
        cfg_thresh = 3'd3;
        cfg_cts_gate = 1'b1;
        cts = 1'b0;
        cfg_len_sel = 3'd3;
        cfg_parity = 3'd1;
        push_char(9'h0C3, 1);
        push_char(9'h03C, 1);
        chk(fifo_level == 3'd2, "R10", "level after two writes", int'(fifo_level), 2);
        chk(below_thr == 1'b1, "R10", "below_thr at level 2 of 3", int'(below_thr), 1);
        lows = 0;
        for (int i = 0; i < 6 * BT; i++) begin
            @(negedge clk);
            if (!txd) lows++;
        end
        chk(lows == 0, "R8", "txd low cycles while cts low", lows, 0);
        chk(fifo_level == 3'd2, "R8", "level held while cts low", int'(fifo_level), 2);
        push_char(9'h0F0, 1);
        chk(below_thr == 1'b0, "R10", "below_thr at level 3 of 3", int'(below_thr), 0);
        cts = 1'b1;
        drain();
        chk(below_thr == 1'b1, "R10", "below_thr after drain", int'(below_thr), 1);

        // R9 depth limit and sticky overflow for every depth
        for (int d = 1; d <= 4; d++) begin
            do_reset();
            cfg_depth_m1 = 2'(d - 1);
            cfg_cts_gate = 1'b1;
            cts = 1'b0;
            for (int k = 0; k < d; k++) push_char(9'($urandom), 1);
            chk(overflow == 1'b0, "R9", "no overflow at exact depth", int'(overflow), 0);
            push_char(9'($urandom), 0);
            push_char(9'($urandom), 0);
            chk(int'(fifo_level) == d, "R9", "level capped at depth", int'(fifo_level), d);
            chk(overflow == 1'b1, "R9", "overflow after dropped write", int'(overflow), 1);
            cts = 1'b1;
            drain();
            chk(overflow == 1'b1, "R9", "overflow sticky", int'(overflow), 1);
        end

        // R6 auto rts drop after a burst
        do_reset();
        cfg_auto_rts = 1'b1;
        cfg_cts_gate = 1'b0;
        cfg_depth_m1 = 2'd3;
        cfg_len_sel = 3'd0;
        cfg_parity = 3'd0;
        cfg_two_stop = 1'b1;
        push_char(9'h015, 1);
        push_char(9'h00A, 1);
        push_char(9'h01F, 1);
        drain();
        chk(rts == 1'b0, "R6", "rts after burst", int'(rts), 0);
        chk(tx_empty == 1'b1, "R6", "tx_empty after burst", int'(tx_empty), 1);

        // random configurations and traffic
        do_reset();
        for (int t = 0; t < 30; t++) begin
            int nch;
            cfg_len_sel  = 3'($urandom_range(0, 7));
            cfg_parity   = 3'($urandom_range(0, 7));
            cfg_two_stop = 1'($urandom_range(0, 1));
            cfg_auto_rts = 1'($urandom_range(0, 1));
            cfg_cts_gate = 1'($urandom_range(0, 1));
            cfg_depth_m1 = 2'($urandom_range(0, 3));
            cts = 1'b1;
            repeat (2) @(negedge clk);
            nch = $urandom_range(1, 6);
            for (int k = 0; k < nch; k++) begin
                while (int'(fifo_level) > int'(cfg_depth_m1)) @(negedge clk);
                push_char(9'($urandom), 1);
                repeat ($urandom_range(0, 20)) @(negedge clk);
            end
            drain();
            if (cfg_auto_rts)
                chk(rts == 1'b0, "R6", "rts after random burst", int'(rts), 0);
            chk(overflow == 1'b0, "R9", "no overflow with room", int'(overflow), 0);
        end

        finish_run();
    end

endmodule